// File: doc/BRIEF.md
# UART Register, Status and Interrupt Unit

This block is the software-facing side of a serial port. It holds the control word, a set of event flags, a 9-bit receive holding register and a 9-bit transmit holding register, and it sits between a 32-bit register bus, a receiver that delivers finished characters as single-cycle strobes, and a transmitter that takes one pending character at a time. Bit-level shifting, baud timing and any line protocol live outside the block. Only their results reach it: a character strobe, three line-event strobes, and a done strobe from the transmitter.

Software enables the port through the control word, reads characters and flags over the bus, and clears flags by writing ones to a dedicated clear word. One level interrupt line combines each flag with its enable bit. The receive path has overrun detection that software can switch off, and an explicit flush request that drops the held character.

The bus uses byte addresses, and only whole 32-bit words are accessed, so the low two address bits are ignored. Word 0 is control, 1 is status, 2 is clear, 3 is request, 4 is receive data and 5 is transmit data. Read data is combinational for the addressed word. A read's side effect, and any write, take effect at the clock edge that ends the access cycle.

Top module: `uart_sir_top`

## Requirements
- R1: After synchronous reset, status reads 0x020000C0 (bits 25, 7 = transmit-empty and 6 = transmit-complete set). The control word, the receive data and the transmit data read zero. Both irq and tx_req are low.
- R2: The control word stores its defined bits and reads back 0 elsewhere. The defined bits are 0 port enable, 1 receive enable, 2 transmit enable, 4 idle ie, 5 receive-full ie, 6 transmit-complete ie, 7 transmit-empty ie, 8 parity ie, 9 error ie and 10 overrun-off. Each control write copies bit 2 into status bit 21 and bit 1 into status bit 22.
- R3: A received character is dropped unless both the port enable and the receive enable are set. A dropped character leaves the receive data and receive-full (status bit 5) unchanged.
- R4: An accepted character is stored, and receive-full is set, when receive-full is clear or overrun-off is set.
- R5: A character accepted while receive-full is set and overrun-off is clear sets overrun (status bit 3). The held character is kept.
- R6: Reading receive data (word 4) returns the character in bits 8:0 and clears receive-full. A character arriving in the same cycle as that read is stored, and no overrun is raised.
- R7: Writing ones to the clear word (word 2) clears the matching status bits. Writes to status (word 1) and to receive data have no effect. The clear word and the request word (word 3) read zero.
- R8: Writing the request word with bit 0 set clears receive-full.
- R9: Writing transmit data (word 5) stores bits 8:0 and clears transmit-empty. tx_req is high while transmit-empty is clear and the transmit enable is set. A tx_done strobe sets transmit-empty and transmit-complete.
- R10: The parity, framing and idle strobes set status bits 0, 1 and 4 while the port enable and the receive enable are set. Otherwise they are ignored.
- R11: irq is high when any of these pairs holds: transmit-empty with its ie, transmit-complete with its ie, receive-full with its ie, idle with its ie, parity with its ie, framing with the error ie, or overrun with either the receive-full ie or the error ie. Clearing the flag drops irq one cycle later.
- R12: Words 6 and 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe (gates read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| rx_valid | input | 1 | One-cycle strobe: character received |
| rx_data | input | DATA_W | Received character |
| ev_parity | input | 1 | Parity error strobe from receiver |
| ev_frame | input | 1 | Framing error strobe from receiver |
| ev_idle | input | 1 | Idle line strobe from receiver |
| tx_req | output | 1 | Character pending for the transmitter |
| tx_data | output | DATA_W | Pending transmit character |
| tx_done | input | 1 | Transmitter finished the pending character |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a read of receive data that coincides with a new character arriving. Overrun must then be judged against the flag as freed by the read, not the flag as it was at the start of the cycle. The bench drives the read strobe and rx_valid in the same cycle and compares the returned (old) character. It then checks that receive-full is set, overrun is clear and the new character is held. Overrun with overrun-off set, and the different paths into irq, are each reached by pairing one flag with one enable at a time and clearing the flag through the clear word.

// File: rtl/uart_sir_pkg.sv
package uart_sir_pkg;

    localparam int WORD_W = 32;

    // word indices (byte address >> 2)
    localparam int RS_CTRL = 0;
    localparam int RS_STAT = 1;
    localparam int RS_CLR  = 2;
    localparam int RS_REQ  = 3;
    localparam int RS_RXD  = 4;
    localparam int RS_TXD  = 5;

    // control word bit positions
    localparam int CB_EN       = 0;
    localparam int CB_RXEN     = 1;
    localparam int CB_TXEN     = 2;
    localparam int CB_IE_IDLE  = 4;
    localparam int CB_IE_RXNE  = 5;
    localparam int CB_IE_TC    = 6;
    localparam int CB_IE_TXE   = 7;
    localparam int CB_IE_PAR   = 8;
    localparam int CB_IE_ERR   = 9;
    localparam int CB_OVR_OFF  = 10;
    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_07F7;

    // status word bit positions; the clear word decodes the same positions
    localparam int SB_PAR   = 0;
    localparam int SB_FRM   = 1;
    localparam int SB_OVR   = 3;
    localparam int SB_IDLE  = 4;
    localparam int SB_RXNE  = 5;
    localparam int SB_TC    = 6;
    localparam int SB_TXE   = 7;
    localparam int SB_TXACK = 21;
    localparam int SB_RXACK = 22;
    localparam int SB_GUARD = 25;
    localparam logic [WORD_W-1:0] STAT_MASK = 32'h0260_00FB;
    localparam logic [WORD_W-1:0] STAT_RST  = 32'h0200_00C0;

    // request word
    localparam int QB_RXFLUSH = 0;

    typedef struct packed {
        logic ovr_off;
        logic ie_err;
        logic ie_par;
        logic ie_txe;
        logic ie_tc;
        logic ie_rxne;
        logic ie_idle;
        logic tx_en;
        logic rx_en;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic rd_rxd;
        logic wr_ctrl;
        logic wr_clr;
        logic wr_req;
        logic wr_txd;
    } acc_t;

    function automatic ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en      = w[CB_EN];
        c.rx_en   = w[CB_RXEN];
        c.tx_en   = w[CB_TXEN];
        c.ie_idle = w[CB_IE_IDLE];
        c.ie_rxne = w[CB_IE_RXNE];
        c.ie_tc   = w[CB_IE_TC];
        c.ie_txe  = w[CB_IE_TXE];
        c.ie_par  = w[CB_IE_PAR];
        c.ie_err  = w[CB_IE_ERR];
        c.ovr_off = w[CB_OVR_OFF];
        return c;
    endfunction

endpackage

// File: rtl/uart_sir_decode.sv
module uart_sir_decode
    import uart_sir_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic              bus_ren,
    output logic [IDX_W-1:0]  idx_o,
    output acc_t              acc_o
);
    logic [1:0] unused_lo;
    assign unused_lo = bus_addr[1:0];
    assign idx_o     = bus_addr[ADDR_W-1:2];

    always_comb begin
        acc_o.rd_rxd  = bus_ren & (idx_o == IDX_W'(RS_RXD));
        acc_o.wr_ctrl = bus_wen & (idx_o == IDX_W'(RS_CTRL));
        acc_o.wr_clr  = bus_wen & (idx_o == IDX_W'(RS_CLR));
        acc_o.wr_req  = bus_wen & (idx_o == IDX_W'(RS_REQ));
        acc_o.wr_txd  = bus_wen & (idx_o == IDX_W'(RS_TXD));
    end
endmodule

// File: rtl/uart_sir_flags.sv
module uart_sir_flags
    import uart_sir_pkg::*;
#(
    parameter int                  W    = WORD_W,
    parameter logic [WORD_W-1:0]   MASK = STAT_MASK,
    parameter logic [WORD_W-1:0]   RSTV = STAT_RST
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    // set wins over clear when both hit one bit in the same cycle
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_ff
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= RSTV[i];
                else     q <= (q & ~clr_i[i]) | set_i[i];
            end
            assign stat_o[i] = q;
        end else begin : g_tie
            logic unused_b;
            assign unused_b  = set_i[i] ^ clr_i[i];
            assign stat_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/uart_sir_irq.sv
module uart_sir_irq
    import uart_sir_pkg::*;
(
    input  logic [WORD_W-1:0] stat_i,
    input  ctrl_t             ctrl_i,
    output logic              irq_o
);
    logic unused_in;
    assign unused_in = ^{stat_i[WORD_W-1:8], stat_i[2],
                         ctrl_i.en, ctrl_i.rx_en, ctrl_i.tx_en, ctrl_i.ovr_off};

    assign irq_o = (stat_i[SB_TXE]  & ctrl_i.ie_txe)
                 | (stat_i[SB_TC]   & ctrl_i.ie_tc)
                 | (stat_i[SB_RXNE] & ctrl_i.ie_rxne)
                 | (stat_i[SB_IDLE] & ctrl_i.ie_idle)
                 | (stat_i[SB_PAR]  & ctrl_i.ie_par)
                 | (stat_i[SB_FRM]  & ctrl_i.ie_err)
                 | (stat_i[SB_OVR]  & (ctrl_i.ie_rxne | ctrl_i.ie_err));
endmodule

// File: rtl/uart_sir_top.sv
module uart_sir_top
    import uart_sir_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic              bus_ren,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              ev_parity,
    input  logic              ev_frame,
    input  logic              ev_idle,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_done,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int PAD_W = WORD_W - DATA_W;

    logic [IDX_W-1:0]  idx;
    acc_t              acc;
    logic [WORD_W-1:0] ctrl_w_q;
    ctrl_t             ctrl;
    logic [WORD_W-1:0] stat;
    logic [WORD_W-1:0] set_vec, clr_vec;
    logic [DATA_W-1:0] rxd_q, txd_q;
    logic              rx_live, rx_ok, rxne_eff, rx_store;

    uart_sir_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_wen  (bus_wen),
        .bus_ren  (bus_ren),
        .idx_o    (idx),
        .acc_o    (acc)
    );

    always_ff @(posedge clk) begin
        if (rst)              ctrl_w_q <= '0;
        else if (acc.wr_ctrl) ctrl_w_q <= bus_wdata & CTRL_MASK;
    end
    assign ctrl = ctrl_unpack(ctrl_w_q);

    assign rx_live = ctrl.en & ctrl.rx_en;
    assign rx_ok   = rx_valid & rx_live;

    always_comb begin
        clr_vec = acc.wr_clr ? bus_wdata : '0;
        if (acc.rd_rxd)                           clr_vec[SB_RXNE]  = 1'b1;
        if (acc.wr_req && bus_wdata[QB_RXFLUSH]) clr_vec[SB_RXNE]  = 1'b1;
        if (acc.wr_txd)                           clr_vec[SB_TXE]   = 1'b1;
        if (acc.wr_ctrl) begin
            clr_vec[SB_TXACK] = 1'b1;
            clr_vec[SB_RXACK] = 1'b1;
        end
    end

    // receive-full as it stands after this cycle's read, flush or clear
    assign rxne_eff = stat[SB_RXNE] & ~clr_vec[SB_RXNE];
    assign rx_store = rx_ok & ~(rxne_eff & ~ctrl.ovr_off);

    always_comb begin
        set_vec           = '0;
        set_vec[SB_PAR]   = ev_parity & rx_live;
        set_vec[SB_FRM]   = ev_frame  & rx_live;
        set_vec[SB_IDLE]  = ev_idle   & rx_live;
        set_vec[SB_OVR]   = rx_ok & ~rx_store;
        set_vec[SB_RXNE]  = rx_store;
        set_vec[SB_TC]    = tx_done;
        set_vec[SB_TXE]   = tx_done & ~acc.wr_txd;
        set_vec[SB_TXACK] = acc.wr_ctrl & bus_wdata[CB_TXEN];
        set_vec[SB_RXACK] = acc.wr_ctrl & bus_wdata[CB_RXEN];
    end

    uart_sir_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_q <= '0;
            txd_q <= '0;
        end else begin
            if (rx_store)   rxd_q <= rx_data;
            if (acc.wr_txd) txd_q <= bus_wdata[DATA_W-1:0];
        end
    end

    assign tx_req  = ctrl.tx_en & ~stat[SB_TXE];
    assign tx_data = txd_q;

    always_comb begin
        unique case (idx)
            IDX_W'(RS_CTRL): bus_rdata = ctrl_w_q;
            IDX_W'(RS_STAT): bus_rdata = stat;
            IDX_W'(RS_RXD):  bus_rdata = {{PAD_W{1'b0}}, rxd_q};
            IDX_W'(RS_TXD):  bus_rdata = {{PAD_W{1'b0}}, txd_q};
            default:         bus_rdata = '0;
        endcase
    end

    uart_sir_irq u_irq (
        .stat_i (stat),
        .ctrl_i (ctrl),
        .irq_o  (irq)
    );
endmodule

// File: rtl/uart_sir_chk.sv
module uart_sir_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic              bus_ren,
    input logic [31:0]       bus_wdata,
    input logic              rx_valid,
    input logic [31:0]       stat,
    input logic [31:0]       ctrl_w_q,
    input logic [DATA_W-1:0] rxd_q,
    input logic              irq
);
    logic [ADDR_W-3:0] w;
    logic in_rxd, in_txd, in_ctrl, in_clr, in_req;
    assign w       = bus_addr[ADDR_W-1:2];
    assign in_rxd  = (w == (ADDR_W-2)'(4));
    assign in_txd  = (w == (ADDR_W-2)'(5));
    assign in_ctrl = (w == (ADDR_W-2)'(0));
    assign in_clr  = (w == (ADDR_W-2)'(2));
    assign in_req  = (w == (ADDR_W-2)'(3));

    AST_DROP_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !(ctrl_w_q[0] && ctrl_w_q[1])) |=> $stable(rxd_q)); // R3

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ctrl_w_q[0] && ctrl_w_q[1] && !ctrl_w_q[10] && stat[5]
         && !(bus_ren && in_rxd) && !(bus_wen && (in_clr || in_req || in_ctrl)))
        |=> (stat[3] && $stable(rxd_q))); // R5

    AST_RXD_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (bus_ren && in_rxd && !rx_valid) |=> !stat[5]); // R6

    AST_TXD_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && in_txd) |=> !stat[7]); // R9

    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && in_ctrl) |=>
        (stat[21] == $past(bus_wdata[2]) && stat[22] == $past(bus_wdata[1]))); // R2

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_w_q & 32'h0000_03F0) == 32'h0) |-> !irq); // R11
endmodule

bind uart_sir_top uart_sir_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_ren   (bus_ren),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .stat      (stat),
    .ctrl_w_q  (ctrl_w_q),
    .rxd_q     (rxd_q),
    .irq       (irq)
);

// File: tb/tb_uart_sir_top.sv
`timescale 1ns/1ps
module tb_uart_sir_top;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wen = 1'b0, bus_ren = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              ev_parity = 1'b0, ev_frame = 1'b0, ev_idle = 1'b0;
    logic              tx_req;
    logic [DATA_W-1:0] tx_data;
    logic              tx_done = 1'b0;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    uart_sir_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .ev_parity(ev_parity),
        .ev_frame(ev_frame), .ev_idle(ev_idle), .tx_req(tx_req),
        .tx_data(tx_data), .tx_done(tx_done), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-compare, 2 receive strobe
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 37;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd1, 5'h04, 32'h0, 32'h0200_00C0, 4'd1},  // R1 reset status
        '{2'd0, 5'h00, 32'h7, 32'h0, 4'd2},
        '{2'd1, 5'h00, 32'h0, 32'h7, 4'd2},          // R2
        '{2'd1, 5'h04, 32'h0, 32'h0260_00C0, 4'd2},  // R2 ack bits
        '{2'd2, 5'h00, 32'h1A5, 32'h0, 4'd4},
        '{2'd1, 5'h04, 32'h0, 32'h0260_00E0, 4'd4},  // R4
        '{2'd1, 5'h10, 32'h0, 32'h1A5, 4'd6},        // R6
        '{2'd1, 5'h04, 32'h0, 32'h0260_00C0, 4'd6},  // R6
        '{2'd2, 5'h00, 32'h011, 32'h0, 4'd5},
        '{2'd2, 5'h00, 32'h022, 32'h0, 4'd5},
        '{2'd1, 5'h04, 32'h0, 32'h0260_00E8, 4'd5},  // R5
        '{2'd1, 5'h10, 32'h0, 32'h011, 4'd5},        // R5 held data
        '{2'd0, 5'h08, 32'h8, 32'h0, 4'd7},
        '{2'd1, 5'h04, 32'h0, 32'h0260_00C0, 4'd7},  // R7
        '{2'd0, 5'h00, 32'h407, 32'h0, 4'd4},
        '{2'd2, 5'h00, 32'h033, 32'h0, 4'd4},
        '{2'd2, 5'h00, 32'h044, 32'h0, 4'd4},
        '{2'd1, 5'h04, 32'h0, 32'h0260_00E0, 4'd4},  // R4 overrun off
        '{2'd1, 5'h10, 32'h0, 32'h044, 4'd4},
        '{2'd2, 5'h00, 32'h055, 32'h0, 4'd8},
        '{2'd0, 5'h0C, 32'h1, 32'h0, 4'd8},
        '{2'd1, 5'h04, 32'h0, 32'h0260_00C0, 4'd8},  // R8
        '{2'd1, 5'h0C, 32'h0, 32'h0, 4'd7},          // R7
        '{2'd1, 5'h08, 32'h0, 32'h0, 4'd7},
        '{2'd0, 5'h04, 32'h0, 32'h0, 4'd7},
        '{2'd1, 5'h04, 32'h0, 32'h0260_00C0, 4'd7},
        '{2'd0, 5'h10, 32'h1FF, 32'h0, 4'd7},
        '{2'd1, 5'h10, 32'h0, 32'h055, 4'd7},
        '{2'd0, 5'h14, 32'h1C3, 32'h0, 4'd9},
        '{2'd1, 5'h04, 32'h0, 32'h0260_0040, 4'd9},  // R9
        '{2'd1, 5'h14, 32'h0, 32'h1C3, 4'd9},
        '{2'd0, 5'h18, 32'hFFFF_FFFF, 32'h0, 4'd12},
        '{2'd1, 5'h18, 32'h0, 32'h0, 4'd12},         // R12
        '{2'd1, 5'h04, 32'h0, 32'h0260_0040, 4'd12},
        '{2'd1, 5'h00, 32'h0, 32'h407, 4'd12},
        '{2'd0, 5'h00, 32'h003, 32'h0, 4'd2},
        '{2'd1, 5'h04, 32'h0, 32'h0240_0040, 4'd2}   // R2 tx ack drops
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(posedge clk); #1;
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp,
                      input logic [31:0] mask, input string tag);
        @(negedge clk);
        bus_addr = a; bus_ren = 1'b1;
        #1;
        check(tag, bus_rdata & mask, exp & mask);
        @(posedge clk); #1;
        bus_ren = 1'b0;
    endtask

    task automatic rx(input logic [DATA_W-1:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(posedge clk); #1; tx_done = 1'b0;
    endtask

    task automatic pulse_ev(input logic p, input logic f, input logic i);
        @(negedge clk); ev_parity = p; ev_frame = f; ev_idle = i;
        @(posedge clk); #1; ev_parity = 1'b0; ev_frame = 1'b0; ev_idle = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        check(tag, {31'h0, irq}, {31'h0, exp});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 outputs after reset
        @(negedge clk);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 tx_req", {31'h0, tx_req}, 32'h0);

        for (int k = 0; k < NSTEP; k++) begin
            case (STEPS[k].op)
                2'd0: wr(STEPS[k].addr, STEPS[k].data);
                2'd1: rd(STEPS[k].addr, STEPS[k].exp, 32'hFFFF_FFFF,
                         $sformatf("R%0d step %0d", STEPS[k].req, k));
                default: rx(STEPS[k].data[DATA_W-1:0]);
            endcase
        end

        // R9 transmit hand-off
        @(negedge clk);
        check("R9 tx_req off while transmit disabled", {31'h0, tx_req}, 32'h0);
        wr(5'h00, 32'h007);
        @(negedge clk);
        check("R9 tx_req pending", {31'h0, tx_req}, 32'h1);
        check("R9 tx_data", {23'h0, tx_data}, 32'h1C3);
        pulse_done();
        rd(5'h04, 32'h0260_00C0, 32'hFFFF_FFFF, "R9 done sets TXE TC");
        check("R9 tx_req after done", {31'h0, tx_req}, 32'h0);

        // R11 interrupt pairs
        chk_irq(1'b0, "R11 no enables");
        wr(5'h00, 32'h087); chk_irq(1'b1, "R11 txe");
        wr(5'h08, 32'h080); chk_irq(1'b0, "R11 txe cleared");
        wr(5'h00, 32'h047); chk_irq(1'b1, "R11 tc");
        wr(5'h08, 32'h040); chk_irq(1'b0, "R11 tc cleared");
        wr(5'h00, 32'h207);
        rx(9'h0A1); rx(9'h0A2);
        chk_irq(1'b1, "R11 overrun via error ie");
        wr(5'h00, 32'h007); chk_irq(1'b0, "R11 overrun masked");
        wr(5'h00, 32'h027); chk_irq(1'b1, "R11 overrun via rx ie");
        wr(5'h08, 32'h028); chk_irq(1'b0, "R11 rx and overrun cleared");

        // R10 line events
        wr(5'h00, 32'h007);
        pulse_ev(1'b1, 1'b1, 1'b1);
        rd(5'h04, 32'h13, 32'h1B, "R10 events set");
        wr(5'h00, 32'h107); chk_irq(1'b1, "R11 parity");
        wr(5'h08, 32'h001); chk_irq(1'b0, "R11 parity cleared");
        wr(5'h00, 32'h207); chk_irq(1'b1, "R11 framing");
        wr(5'h08, 32'h002);
        wr(5'h00, 32'h017); chk_irq(1'b1, "R11 idle");
        wr(5'h08, 32'h010); chk_irq(1'b0, "R11 idle cleared");

        // R3 receiver disabled
        wr(5'h00, 32'h005);
        rd(5'h04, 32'h0, 32'h0040_0000, "R2 rx ack low");
        rx(9'h0AA);
        rd(5'h04, 32'h0, 32'h20, "R3 rx disabled flag");
        rd(5'h10, 32'h0A1, 32'hFFFF_FFFF, "R3 rx disabled data");
        wr(5'h00, 32'h006);
        rx(9'h0BB);
        rd(5'h04, 32'h0, 32'h20, "R3 port disabled flag");
        pulse_ev(1'b1, 1'b0, 1'b0);
        rd(5'h04, 32'h0, 32'h01, "R10 event ignored when disabled");

        // R6 read and arrival in the same cycle
        wr(5'h00, 32'h007);
        rx(9'h101);
        @(negedge clk);
        bus_addr = 5'h10; bus_ren = 1'b1; rx_valid = 1'b1; rx_data = 9'h102;
        #1;
        check("R6 same-cycle read data", bus_rdata, 32'h101);
        @(posedge clk); #1;
        bus_ren = 1'b0; rx_valid = 1'b0;
        rd(5'h04, 32'h20, 32'h28, "R6 same-cycle flags");
        rd(5'h10, 32'h102, 32'hFFFF_FFFF, "R6 same-cycle new data");

        // R2 undefined control bits
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'h7F7, 32'hFFFF_FFFF, "R2 control mask");

        // R1 reset again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd(5'h04, 32'h0200_00C0, 32'hFFFF_FFFF, "R1 status");
        rd(5'h00, 32'h0, 32'hFFFF_FFFF, "R1 control");
        rd(5'h10, 32'h0, 32'hFFFF_FFFF, "R1 rx data");
        rd(5'h14, 32'h0, 32'hFFFF_FFFF, "R1 tx data");
        @(negedge clk);
        check("R1 irq low", {31'h0, irq}, 32'h0);
        check("R1 tx_req low", {31'h0, tx_req}, 32'h0);

        summary();
    end
endmodule